// File: doc/BRIEF.md
# Instruction Fetch Next-Address Unit

This block owns the program counter of a simple in-order core and produces the byte address of the instruction to fetch. Instructions are four bytes wide and always word aligned, so only the word part of the counter is stored. The byte address is formed by appending zero bits below it. Every cycle the unit works out three candidate addresses: the next sequential word, a PC-relative branch target and a region-relative jump target. It then loads one of them into the counter on the rising clock edge.

The decode stage gives the unit a branch request and the comparison result from the ALU. It also gives a jump request, the signed 16-bit branch offset and the 26-bit jump target field. A branch is taken only when its request and the equality flag are both high. A jump wins over any branch. A priority decoder reduces the requests to one of three named sources: `SRC_SEQ`, `SRC_BRANCH` and `SRC_JUMP`. The output multiplexer switches on that source value.

Top module: `npc_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, `iaddr` reads 0 after that edge.
- R2: The low two bits of `iaddr` are always 0, and the upper 30 bits are the stored word counter.
- R3: When `rst`, `br_sel` and `jmp_sel` are all low at an edge, `iaddr` increases by 4 after that edge.
- R4: When `br_sel` and `eq_flag` are high and `jmp_sel` is low, the word counter becomes word+1+sign-extended `imm` (the offset counts words, and bit 15 of `imm` is its sign).
- R5: `br_sel` with `eq_flag` low gives the sequential update. `eq_flag` high with `br_sel` low also gives the sequential update.
- R6: A negative offset moves backwards. An offset of 0xFFFF leaves the counter unchanged, and 0x8000 moves it back by 32767 words.
- R7: When `jmp_sel` is high, the word counter becomes {the top 4 bits of word+1, `jtarget`}. The region bits therefore come from the incremented counter, even when that increment crosses a region boundary.
- R8: When `jmp_sel` is high at the same time as a taken branch, the jump is applied.
- R9: All updates wrap modulo 2^30 words, with no overflow indication.
- R10: `rst` takes priority over branch and jump requests in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| br_sel | input | 1 | Branch request from decode |
| eq_flag | input | 1 | Operand equality flag from the ALU |
| jmp_sel | input | 1 | Jump request from decode |
| imm | input | 16 | Signed branch offset in words |
| jtarget | input | 26 | Jump target word field |
| iaddr | output | 32 | Instruction byte address |

## Verification
The bench builds the unit with its default parameters: a 32-bit address, 2 alignment bits, a 16-bit offset and a 26-bit jump field. These values let a single branch with offset -2 from address 0 reach the top of the 30-bit space, so that wrap-around in both directions can be tested within a few cycles. Starting from reset, one jump to the largest target field puts the counter on the last word of region 0. The next jump then shows the region bits being taken from the incremented counter.

// File: rtl/npc_pkg.sv
package npc_pkg;

    // Source selected for the next word address
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2
    } npc_src_e;

endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
    parameter int W = 30
) (
    input  logic [W-1:0] pc_word,
    output logic [W-1:0] pc_inc
);
    // modulo 2^W increment
    always_comb begin
        pc_inc = pc_word + {{(W-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/npc_btarget.sv
module npc_btarget #(
    parameter int W     = 30,
    parameter int IMM_W = 16
) (
    input  logic [W-1:0]     pc_inc,
    input  logic [IMM_W-1:0] imm,
    output logic [W-1:0]     br_word
);
    logic [W-1:0] ofs_ext;

    generate
        if (W > IMM_W) begin : g_sext
            always_comb ofs_ext = {{(W-IMM_W){imm[IMM_W-1]}}, imm};
        end else begin : g_trunc
            always_comb ofs_ext = imm[W-1:0];
        end
    endgenerate

    always_comb begin
        br_word = pc_inc + ofs_ext;
    end
endmodule

// File: rtl/npc_jtarget.sv
module npc_jtarget #(
    parameter int W     = 30,
    parameter int TGT_W = 26
) (
    input  logic [W-1:0]     pc_inc,
    input  logic [TGT_W-1:0] tgt,
    output logic [W-1:0]     jmp_word
);
    generate
        if (W > TGT_W) begin : g_region
            always_comb jmp_word = {pc_inc[W-1:TGT_W], tgt};
        end else begin : g_full
            logic unused_inc;
            always_comb unused_inc = ^pc_inc;
            always_comb jmp_word = tgt[W-1:0];
        end
    endgenerate
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int W = 30
) (
    input  logic         br_sel,
    input  logic         eq_flag,
    input  logic         jmp_sel,
    input  logic [W-1:0] seq_word,
    input  logic [W-1:0] br_word,
    input  logic [W-1:0] jmp_word,
    output logic [W-1:0] next_word
);
    npc_src_e src;

    // priority: jump, then taken branch, then sequential
    always_comb begin
        if (jmp_sel)
            src = SRC_JUMP;
        else if (br_sel && eq_flag)
            src = SRC_BRANCH;
        else
            src = SRC_SEQ;
    end

    always_comb begin
        unique case (src)
            SRC_SEQ:    next_word = seq_word;
            SRC_BRANCH: next_word = br_word;
            SRC_JUMP:   next_word = jmp_word;
            default:    next_word = seq_word;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
    parameter int ADDR_W = 32,
    parameter int ALIGN  = 2,
    parameter int IMM_W  = 16,
    parameter int TGT_W  = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              br_sel,
    input  logic              eq_flag,
    input  logic              jmp_sel,
    input  logic [IMM_W-1:0]  imm,
    input  logic [TGT_W-1:0]  jtarget,
    output logic [ADDR_W-1:0] iaddr
);
    localparam int PC_W = ADDR_W - ALIGN;

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] br_word;
    logic [PC_W-1:0] jmp_word;
    logic [PC_W-1:0] pc_d;

    npc_incr #(.W(PC_W)) incr_i (
        .pc_word (pc_q),
        .pc_inc  (pc_inc)
    );

    npc_btarget #(.W(PC_W), .IMM_W(IMM_W)) btgt_i (
        .pc_inc  (pc_inc),
        .imm     (imm),
        .br_word (br_word)
    );

    npc_jtarget #(.W(PC_W), .TGT_W(TGT_W)) jtgt_i (
        .pc_inc   (pc_inc),
        .tgt      (jtarget),
        .jmp_word (jmp_word)
    );

    npc_select #(.W(PC_W)) sel_i (
        .br_sel    (br_sel),
        .eq_flag   (eq_flag),
        .jmp_sel   (jmp_sel),
        .seq_word  (pc_inc),
        .br_word   (br_word),
        .jmp_word  (jmp_word),
        .next_word (pc_d)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else
            pc_q <= pc_d;
    end

    // output formation
    always_comb begin
        iaddr = {pc_q, {ALIGN{1'b0}}};
    end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int ADDR_W = 32,
    parameter int ALIGN  = 2,
    parameter int IMM_W  = 16,
    parameter int TGT_W  = 26
) (
    input logic              clk,
    input logic              rst,
    input logic              br_sel,
    input logic              eq_flag,
    input logic              jmp_sel,
    input logic [IMM_W-1:0]  imm,
    input logic [TGT_W-1:0]  jtarget,
    input logic [ADDR_W-1:0] iaddr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN;

    logic [ADDR_W-1:0] br_ofs;
    logic              seen_edge;

    always_comb br_ofs = {{(ADDR_W-IMM_W-ALIGN){imm[IMM_W-1]}}, imm, {ALIGN{1'b0}}};

    always_ff @(posedge clk) seen_edge <= 1'b1;

    always @(posedge clk) begin
        if (seen_edge === 1'b1 && $past(rst))
            assert_reset_zero_R1: assert (iaddr == '0);
    end

    assert_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        iaddr[ALIGN-1:0] == '0);

    assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!br_sel && !jmp_sel) |=> iaddr == $past(iaddr) + STEP);

    assert_branch_taken_R4: assert property (@(posedge clk) disable iff (rst)
        (br_sel && eq_flag && !jmp_sel) |=> iaddr == $past(iaddr) + STEP + $past(br_ofs));

    assert_branch_untaken_R5: assert property (@(posedge clk) disable iff (rst)
        (br_sel && !eq_flag && !jmp_sel) |=> iaddr == $past(iaddr) + STEP);

    assert_jump_field_R8: assert property (@(posedge clk) disable iff (rst)
        jmp_sel |=> iaddr[ALIGN+TGT_W-1:ALIGN] == $past(jtarget));

    assert_jump_region_R7: assert property (@(posedge clk) disable iff (rst)
        jmp_sel |=> iaddr[ADDR_W-1:ALIGN+TGT_W] == $past((iaddr + STEP) >> (ALIGN+TGT_W)) );
endmodule

bind npc_unit npc_unit_chk #(
    .ADDR_W (ADDR_W),
    .ALIGN  (ALIGN),
    .IMM_W  (IMM_W),
    .TGT_W  (TGT_W)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .br_sel  (br_sel),
    .eq_flag (eq_flag),
    .jmp_sel (jmp_sel),
    .imm     (imm),
    .jtarget (jtarget),
    .iaddr   (iaddr)
);

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_sel = 1'b0;
    logic        eq_flag = 1'b0;
    logic        jmp_sel = 1'b0;
    logic [15:0] imm = '0;
    logic [25:0] jtarget = '0;
    logic [31:0] iaddr;

    int n_vec = 0;
    int n_bad = 0;
    logic [29:0] m_pc = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_unit dut_i (
        .clk(clk), .rst(rst), .br_sel(br_sel), .eq_flag(eq_flag),
        .jmp_sel(jmp_sel), .imm(imm), .jtarget(jtarget), .iaddr(iaddr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: iaddr=%h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; drives inputs, waits one cycle, checks
    task automatic apply(input logic r, input logic b, input logic e, input logic j,
                         input logic [15:0] im, input logic [25:0] tg, input string req);
        logic [29:0] seq;
        logic [29:0] exp;
        rst = r; br_sel = b; eq_flag = e; jmp_sel = j; imm = im; jtarget = tg;
        seq = m_pc + 30'd1;
        if (r)           exp = '0;
        else if (j)      exp = {seq[29:26], tg};
        else if (b && e) exp = seq + {{14{im[15]}}, im};
        else             exp = seq;
        @(negedge clk);
        m_pc = exp;
        check(req, iaddr, {m_pc, 2'b00});
    endtask

    task automatic t_reset;
        apply(1, 1, 1, 1, 16'h0040, 26'h155, "R1 R10 reset with requests");
        check("R1 absolute zero", iaddr, 32'h0);
    endtask

    task automatic t_sequential;
        apply(0, 0, 0, 0, 16'h1234, 26'h0, "R3 step 1");
        apply(0, 0, 0, 0, 16'h0000, 26'h0, "R3 step 2");
        apply(0, 0, 0, 0, 16'hFFFF, 26'h0, "R3 step 3");
        check("R3 R2 absolute", iaddr, 32'h0000000C);
    endtask

    task automatic t_untaken;
        apply(0, 0, 1, 0, 16'h0010, 26'h0, "R5 eq without branch");
        apply(0, 1, 0, 0, 16'h0010, 26'h0, "R5 branch without eq");
    endtask

    task automatic t_branch;
        apply(0, 1, 1, 0, 16'h0005, 26'h0, "R4 forward branch");
        apply(0, 1, 1, 0, 16'hFFFF, 26'h0, "R6 offset -1 holds");
        apply(0, 1, 1, 0, 16'h8000, 26'h0, "R6 R9 most negative offset");
    endtask

    task automatic t_wrap;
        apply(1, 0, 0, 0, 16'h0, 26'h0, "R1 reset before wrap");
        apply(0, 1, 1, 0, 16'hFFFE, 26'h0, "R9 branch below zero");
        check("R9 R2 top word", iaddr, 32'hFFFFFFFC);
        apply(0, 0, 0, 0, 16'h0, 26'h0, "R9 sequential wrap");
        check("R9 wrapped to zero", iaddr, 32'h0);
    endtask

    task automatic t_jump;
        apply(1, 0, 0, 0, 16'h0, 26'h0, "R1 reset before jump");
        apply(0, 0, 0, 1, 16'h0, 26'h3FFFFFF, "R7 jump to region end");
        check("R7 region end absolute", iaddr, 32'h0FFFFFFC);
        apply(0, 1, 1, 1, 16'h0100, 26'h0000123, "R8 R7 jump over branch, region crossing");
        check("R7 crossed region absolute", iaddr, 32'h1000048C);
    endtask

    task automatic t_reset_mid;
        apply(0, 0, 0, 0, 16'h0, 26'h0, "R3 before reset");
        apply(1, 1, 1, 0, 16'h0020, 26'h0, "R10 reset beats branch");
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_sequential();
        t_untaken();
        t_branch();
        t_wrap();
        t_jump();
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule